// File: doc/BRIEF.md
# Eight-Lane SIMD Fixed-Point Execution Unit

This block executes one decoded instruction per issue on eight lanes together. Each lane holds the private registers of one fragment. A small shared constant store holds values common to all lanes. A source operand that names a constant entry, or one of the two literals carried in the instruction word, gives the same value to every lane. A source that names a register reads each lane's own copy. The data format is signed 16-bit Q8.8 fixed point. The block provides multiply, multiply-add, clamp and move.

An 8-bit active mask handles divergent if/else code. A compare instruction loads the mask with a per-lane "operand is greater than zero" test. The if-path then runs with only those lanes writing back. An invert instruction hands the shared lanes to the else-path, and a restore instruction re-enables every lane. Register results land one clock after acceptance. The issue port holds off for one cycle when the next instruction reads a register that is still in flight.

The surrounding logic fills registers through a per-lane load port, writes constants through their own port, and collects results through a combinational per-lane read port.

Top module: `simd_exec_unit`

## Requirements
- R1: After a synchronous active-high reset, every lane register reads zero, every constant entry is zero, activeMask is 8'hFF and instrReady is high.
- R2: The instruction word is {opcode[56:53], dst[52:50], selA[49:44], selB[43:38], selC[37:32], lit0[31:16], lit1[15:0]}. A selector is {kind[5:4], index[3:0]}, where kind 0 is a lane register (index[2:0]), kind 1 is a constant entry (index), kind 2 is lit0 and kind 3 is lit1. The opcodes are 0 nop, 1 mul, 2 madd, 3 clamp, 4 move, 5 compare, 6 invert and 7 restore, and codes 8 to 15 behave as nop. One accepted instruction computes independently in all eight lanes, each lane using its own registers, with constant and literal operands shared.
- R3: mul gives A*B in Q8.8. The 32-bit product is divided by 256 rounding toward zero and then saturated to the range 16'h8000..16'h7FFF.
- R4: madd takes the product of A and B, divides it by 256 rounding toward zero, adds C, and saturates the sum once to the 16-bit range.
- R5: clamp gives min(max(A, B), C) in signed compares, so C wins when B > C. move copies A.
- R6: A result-writing instruction accepted on edge t updates the registers on edge t+1. Before edge t+1 the read port still shows the old value.
- R7: compare sets mask bit i to 1 exactly when lane i's A is greater than zero (signed). invert complements the mask and restore sets it to 8'hFF. Each of these takes effect on the edge that accepts it. No other opcode, and no idle cycle, changes the mask.
- R8: Writeback updates only lanes whose mask bit is 1. Masked lanes, and the nop, compare, invert and restore opcodes, leave every register unchanged.
- R9: instrReady is low exactly when the instruction in flight writes register d and the offered word has a selector of kind 0 whose index[2:0] equals d. This applies whatever the opcode and whatever instrValid is, and the stall lasts one cycle.
- R10: A constant write takes effect on its edge. An instruction accepted on that same edge reads the previous value.
- R11: The load port writes one register of one lane. When writeback hits the same register of the same lane on the same edge, the writeback value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word offered |
| instrWord | input | 57 | Decoded instruction (layout in R2) |
| instrReady | output | 1 | Unit can accept the offered word |
| cstWe | input | 1 | Constant store write enable |
| cstAddr | input | 4 | Constant entry index |
| cstData | input | 16 | Constant value |
| ldEn | input | 1 | Lane register load enable |
| ldLane | input | 3 | Lane to load |
| ldReg | input | 3 | Register to load |
| ldData | input | 16 | Load value |
| rdLane | input | 3 | Lane to read |
| rdReg | input | 3 | Register to read |
| rdData | output | 16 | Combinational register read value |
| activeMask | output | 8 | Current per-lane active mask |

## Verification
A corrupted lane register or constant entry shows on rdData as soon as the read port addresses it. It also spreads into every later result computed from it, one clock after that instruction is accepted. A wrong mask is visible on activeMask in the cycle after the faulty update, and it shows again in the lanes that do or do not take the next writeback. A wrong in-flight destination shows as instrReady dropping, or failing to drop, in the very next cycle. If that hazard is missed, a stale operand appears in the register written one instruction later.

// File: rtl/simd_pkg.sv
package simd_pkg;
  parameter int LANES  = 8;
  parameter int NREG   = 8;
  parameter int NCONST = 16;
  parameter int DW     = 16;
  parameter int FRAC   = 8;
  parameter int NSRC   = 3;

  localparam int REG_AW   = $clog2(NREG);
  localparam int CONST_AW = $clog2(NCONST);
  localparam int LANE_AW  = $clog2(LANES);
  localparam int OP_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_MUL     = 4'd1,
    OP_MADD    = 4'd2,
    OP_CLMP    = 4'd3,
    OP_MOV     = 4'd4,
    OP_CMPGT   = 4'd5,
    OP_INV     = 4'd6,
    OP_RESTORE = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_CONST = 2'd1,
    SRC_LIT0  = 2'd2,
    SRC_LIT1  = 2'd3
  } srcKind_e;

  typedef struct packed {
    srcKind_e             kind;
    logic [CONST_AW-1:0]  idx;
  } srcSel_t;

  typedef struct packed {
    op_e                op;
    logic [REG_AW-1:0]  dst;
    srcSel_t            selA;
    srcSel_t            selB;
    srcSel_t            selC;
    logic [DW-1:0]      lit0;
    logic [DW-1:0]      lit1;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // strobes from control to datapath
  typedef struct packed {
    logic               accept;
    logic [REG_AW-1:0]  wbDst;
    logic [LANES-1:0]   laneWe;
  } ctrlStrobe_t;

  function automatic logic opWritesReg(op_e op);
    return (op == OP_MUL) || (op == OP_MADD) || (op == OP_CLMP) || (op == OP_MOV);
  endfunction
endpackage

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
(
  input  op_e                  op,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [DW-1:0] c,
  output logic        [DW-1:0] y
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] RND_BIAS = {{(PW-FRAC){1'b0}}, {FRAC{1'b1}}};
  localparam logic signed [PW:0]   SAT_HI   = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0]   SAT_LO   = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] aExt, bExt, prod, prodAdj, scaled;
  logic signed [DW-1:0] addend, lowBound;
  logic signed [PW:0]   sum;
  logic        [DW-1:0] satVal;

  always_comb begin
    aExt    = {{DW{a[DW-1]}}, a};
    bExt    = {{DW{b[DW-1]}}, b};
    prod    = aExt * bExt;
    // bias negative products so the arithmetic shift truncates toward zero
    prodAdj = prod + (prod[PW-1] ? RND_BIAS : '0);
    scaled  = prodAdj >>> FRAC;
    addend  = (op == OP_MADD) ? c : '0;
    sum     = {scaled[PW-1], scaled} + {{(PW+1-DW){addend[DW-1]}}, addend};
    if (sum > SAT_HI)      satVal = SAT_HI[DW-1:0];
    else if (sum < SAT_LO) satVal = SAT_LO[DW-1:0];
    else                   satVal = sum[DW-1:0];

    lowBound = (a < b) ? b : a;

    case (op)
      OP_MUL, OP_MADD: y = satVal;
      OP_CLMP:         y = (lowBound > c) ? c : lowBound;
      OP_MOV:          y = a;
      default:         y = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [NSRC-1:0]   srcIsReg,
  input  logic [REG_AW-1:0] srcReg   [NSRC],
  input  logic [DW-1:0]     srcBcast [NSRC],
  input  logic              accept,
  input  logic              wbWe,
  input  logic [REG_AW-1:0] wbDst,
  input  logic              ldEn,
  input  logic [REG_AW-1:0] ldReg,
  input  logic [DW-1:0]     ldData,
  input  logic [REG_AW-1:0] rdReg,
  output logic [DW-1:0]     rdData,
  output logic              gtZero
);
  logic [DW-1:0] regFile [NREG];
  logic [DW-1:0] opnd    [NSRC];
  logic [DW-1:0] aluY;
  logic [DW-1:0] stageRes;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      opnd[s] = srcIsReg[s] ? regFile[srcReg[s]] : srcBcast[s];
    end
  end

  assign gtZero = !opnd[0][DW-1] && (opnd[0] != '0);
  assign rdData = regFile[rdReg];

  simd_alu alu_i (
    .op (op),
    .a  (opnd[0]),
    .b  (opnd[1]),
    .c  (opnd[2]),
    .y  (aluY)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stageRes <= '0;
    end else if (accept) begin
      stageRes <= aluY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) regFile[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wbWe && wbDst == REG_AW'(r))        regFile[r] <= stageRes;
        else if (ldEn && ldReg == REG_AW'(r))   regFile[r] <= ldData;
      end
    end
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  op_e                 op,
  input  srcSel_t             srcSel [NSRC],
  input  logic [DW-1:0]       lit0,
  input  logic [DW-1:0]       lit1,
  input  ctrlStrobe_t         strobe,
  input  logic                cstWe,
  input  logic [CONST_AW-1:0] cstAddr,
  input  logic [DW-1:0]       cstData,
  input  logic                ldEn,
  input  logic [LANE_AW-1:0]  ldLane,
  input  logic [REG_AW-1:0]   ldReg,
  input  logic [DW-1:0]       ldData,
  input  logic [LANE_AW-1:0]  rdLane,
  input  logic [REG_AW-1:0]   rdReg,
  output logic [DW-1:0]       rdData,
  output logic [LANES-1:0]    gtVec
);
  logic [DW-1:0]     cstStore [NCONST];
  logic [NSRC-1:0]   srcIsReg;
  logic [REG_AW-1:0] srcReg   [NSRC];
  logic [DW-1:0]     srcBcast [NSRC];
  logic [DW-1:0]     laneRd   [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCONST; k++) cstStore[k] <= '0;
    end else if (cstWe) begin
      cstStore[cstAddr] <= cstData;
    end
  end

  // broadcast operand resolution, one per source slot
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign srcIsReg[s] = (srcSel[s].kind == SRC_REG);
    assign srcReg[s]   = srcSel[s].idx[REG_AW-1:0];
    always_comb begin
      case (srcSel[s].kind)
        SRC_CONST: srcBcast[s] = cstStore[srcSel[s].idx];
        SRC_LIT0:  srcBcast[s] = lit0;
        default:   srcBcast[s] = lit1;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane lane_i (
      .clk      (clk),
      .rst      (rst),
      .op       (op),
      .srcIsReg (srcIsReg),
      .srcReg   (srcReg),
      .srcBcast (srcBcast),
      .accept   (strobe.accept),
      .wbWe     (strobe.laneWe[g]),
      .wbDst    (strobe.wbDst),
      .ldEn     (ldEn && (ldLane == LANE_AW'(g))),
      .ldReg    (ldReg),
      .ldData   (ldData),
      .rdReg    (rdReg),
      .rdData   (laneRd[g]),
      .gtZero   (gtVec[g])
    );
  end

  assign rdData = laneRd[rdLane];
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  op_e               op,
  input  logic [REG_AW-1:0] dst,
  input  logic [NSRC-1:0]   srcIsReg,
  input  logic [REG_AW-1:0] srcReg [NSRC],
  input  logic [LANES-1:0]  gtVec,
  output logic              instrReady,
  output logic [LANES-1:0]  activeMask,
  output ctrlStrobe_t       strobe
);
  logic              stageValid;
  logic [REG_AW-1:0] stageDst;
  logic [NSRC-1:0]   srcHit;
  logic              accept;

  for (genvar s = 0; s < NSRC; s++) begin : g_hit
    assign srcHit[s] = srcIsReg[s] && (srcReg[s] == stageDst);
  end

  assign instrReady = !(stageValid && (|srcHit));
  assign accept     = instrValid && instrReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      stageDst   <= '0;
      activeMask <= '1;
    end else begin
      stageValid <= accept && opWritesReg(op);
      if (accept) begin
        stageDst <= dst;
        case (op)
          OP_CMPGT:   activeMask <= gtVec;
          OP_INV:     activeMask <= ~activeMask;
          OP_RESTORE: activeMask <= '1;
          default:    activeMask <= activeMask;
        endcase
      end
    end
  end

  always_comb begin
    strobe.accept = accept;
    strobe.wbDst  = stageDst;
    strobe.laneWe = stageValid ? activeMask : '0;
  end
endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  output logic                instrReady,
  input  logic                cstWe,
  input  logic [CONST_AW-1:0] cstAddr,
  input  logic [DW-1:0]       cstData,
  input  logic                ldEn,
  input  logic [LANE_AW-1:0]  ldLane,
  input  logic [REG_AW-1:0]   ldReg,
  input  logic [DW-1:0]       ldData,
  input  logic [LANE_AW-1:0]  rdLane,
  input  logic [REG_AW-1:0]   rdReg,
  output logic [DW-1:0]       rdData,
  output logic [LANES-1:0]    activeMask
);
  instr_t            ins;
  srcSel_t           srcSel   [NSRC];
  logic [NSRC-1:0]   srcIsReg;
  logic [REG_AW-1:0] srcReg   [NSRC];
  logic [LANES-1:0]  gtVec;
  ctrlStrobe_t       strobe;

  assign ins       = instr_t'(instrWord);
  assign srcSel[0] = ins.selA;
  assign srcSel[1] = ins.selB;
  assign srcSel[2] = ins.selC;

  for (genvar s = 0; s < NSRC; s++) begin : g_ref
    assign srcIsReg[s] = (srcSel[s].kind == SRC_REG);
    assign srcReg[s]   = srcSel[s].idx[REG_AW-1:0];
  end

  simd_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .op         (ins.op),
    .dst        (ins.dst),
    .srcIsReg   (srcIsReg),
    .srcReg     (srcReg),
    .gtVec      (gtVec),
    .instrReady (instrReady),
    .activeMask (activeMask),
    .strobe     (strobe)
  );

  simd_datapath dp_i (
    .clk     (clk),
    .rst     (rst),
    .op      (ins.op),
    .srcSel  (srcSel),
    .lit0    (ins.lit0),
    .lit1    (ins.lit1),
    .strobe  (strobe),
    .cstWe   (cstWe),
    .cstAddr (cstAddr),
    .cstData (cstData),
    .ldEn    (ldEn),
    .ldLane  (ldLane),
    .ldReg   (ldReg),
    .ldData  (ldData),
    .rdLane  (rdLane),
    .rdReg   (rdReg),
    .rdData  (rdData),
    .gtVec   (gtVec)
  );
endmodule

// File: rtl/simd_exec_chk.sv
module simd_exec_chk
  import simd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             instrValid,
  input logic [OP_W-1:0]  opCode,
  input logic             instrReady,
  input logic [LANES-1:0] activeMask
);
  logic accepted;
  logic maskOp;
  assign accepted = instrValid && instrReady;
  assign maskOp   = (opCode == OP_CMPGT) || (opCode == OP_INV) || (opCode == OP_RESTORE);

  AST_RESTORE_ALL: assert property (@(posedge clk) disable iff (rst)
    accepted && opCode == OP_RESTORE |=> activeMask == '1); // R7

  AST_INVERT_MASK: assert property (@(posedge clk) disable iff (rst)
    accepted && opCode == OP_INV |=> activeMask == ~$past(activeMask)); // R7

  AST_MASK_HOLD_OP: assert property (@(posedge clk) disable iff (rst)
    accepted && !maskOp |=> $stable(activeMask)); // R7

  AST_MASK_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> $stable(activeMask)); // R7

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !instrReady |=> instrReady); // R9

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !instrReady |-> $past(accepted)); // R9
endmodule

bind simd_exec_unit simd_exec_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .instrValid (instrValid),
  .opCode     (instrWord[simd_pkg::INSTR_W-1 -: simd_pkg::OP_W]),
  .instrReady (instrReady),
  .activeMask (activeMask)
);

// File: tb/simd_exec_unit_tb_top.sv
module simd_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iValid = 1'b0;
  logic [56:0] iWord = '0;
  logic        iReady;
  logic        cstWe = 1'b0;
  logic [3:0]  cstAddr = '0;
  logic [15:0] cstData = '0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldLane = '0;
  logic [2:0]  ldReg = '0;
  logic [15:0] ldData = '0;
  logic [2:0]  rdLane = '0;
  logic [2:0]  rdReg = '0;
  logic [15:0] rdData;
  logic [7:0]  actMask;

  int nChecks = 0;
  int nFail = 0;
  int nStalls = 0;

  always #10 clk = ~clk;

  simd_exec_unit dut_i (
    .clk(clk), .rst(rst), .instrValid(iValid), .instrWord(iWord), .instrReady(iReady),
    .cstWe(cstWe), .cstAddr(cstAddr), .cstData(cstData),
    .ldEn(ldEn), .ldLane(ldLane), .ldReg(ldReg), .ldData(ldData),
    .rdLane(rdLane), .rdReg(rdReg), .rdData(rdData), .activeMask(actMask)
  );

  // behavioural reference state
  logic [15:0] mReg [8][8];
  logic [15:0] mCst [16];
  logic [7:0]  mMask;
  bit          mPv;
  logic [2:0]  mPdst;
  logic [15:0] mPres [8];

  localparam logic [5:0] LIT0 = 6'b100000;
  localparam logic [5:0] LIT1 = 6'b110000;
  function automatic logic [5:0] rs(int n); return {2'b00, 4'(n)}; endfunction
  function automatic logic [5:0] ks(int n); return {2'b01, 4'(n)}; endfunction

  function automatic logic [56:0] mk(int op, int dst, logic [5:0] a, logic [5:0] b,
                                     logic [5:0] c, logic [15:0] l0, logic [15:0] l1);
    return {4'(op), 3'(dst), a, b, c, l0, l1};
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fetch(int lane, logic [5:0] sel, logic [15:0] l0, logic [15:0] l1);
    case (sel[5:4])
      2'd0: return mReg[lane][sel[2:0]];
      2'd1: return mCst[sel[3:0]];
      2'd2: return l0;
      default: return l1;
    endcase
  endfunction

  function automatic logic [15:0] calc(int op, logic [15:0] a16, logic [15:0] b16, logic [15:0] c16);
    int a = $signed(a16);
    int b = $signed(b16);
    int c = $signed(c16);
    int s;
    case (op)
      1: s = (a * b) / 256;
      2: s = (a * b) / 256 + c;
      3: begin s = (a < b) ? b : a; if (s > c) s = c; end
      default: s = a;
    endcase
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  function automatic bit hazard();
    bit h = 0;
    logic [5:0] sels [3];
    sels[0] = iWord[49:44]; sels[1] = iWord[43:38]; sels[2] = iWord[37:32];
    foreach (sels[k]) if (mPv && sels[k][5:4] == 2'd0 && sels[k][2:0] == mPdst) h = 1;
    return h;
  endfunction

  task automatic modelEdge(bit acc);
    logic [15:0] nReg [8][8];
    logic [15:0] nCst [16];
    logic [7:0]  nMask;
    int op = int'(iWord[56:53]);
    nReg = mReg; nCst = mCst; nMask = mMask;
    if (ldEn) nReg[ldLane][ldReg] = ldData;
    if (mPv) for (int l = 0; l < 8; l++) if (mMask[l]) nReg[l][mPdst] = mPres[l];
    if (cstWe) nCst[cstAddr] = cstData;
    mPv = 0;
    if (acc) begin
      if (op >= 1 && op <= 4) begin
        mPv = 1; mPdst = iWord[52:50];
        for (int l = 0; l < 8; l++)
          mPres[l] = calc(op, fetch(l, iWord[49:44], iWord[31:16], iWord[15:0]),
                               fetch(l, iWord[43:38], iWord[31:16], iWord[15:0]),
                               fetch(l, iWord[37:32], iWord[31:16], iWord[15:0]));
      end else if (op == 5) begin
        for (int l = 0; l < 8; l++)
          nMask[l] = $signed(fetch(l, iWord[49:44], iWord[31:16], iWord[15:0])) > 0;
      end else if (op == 6) nMask = ~mMask;
      else if (op == 7) nMask = 8'hFF;
    end
    mReg = nReg; mCst = nCst; mMask = nMask;
  endtask

  // one clock: compare at negedge, step model at posedge
  task automatic tick(output bit acc);
    bit expReady;
    #1;
    expReady = !hazard();
    check(iReady === expReady, "R9 ready", 16'(iReady), 16'(expReady));
    check(actMask === mMask, "R7 mask", 16'(actMask), 16'(mMask));
    check(rdData === mReg[rdLane][rdReg], "R2 lane read", rdData, mReg[rdLane][rdReg]);
    if (iValid && !expReady) nStalls++;
    acc = iValid && expReady;
    @(posedge clk);
    modelEdge(acc);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bit acc;
    for (int k = 0; k < n; k++) begin
      tick(acc);
      ldEn = 0; cstWe = 0;
    end
  endtask

  task automatic issue(logic [56:0] w);
    bit acc = 0;
    iWord = w; iValid = 1;
    while (!acc) begin
      tick(acc);
      ldEn = 0; cstWe = 0;
    end
    iValid = 0;
  endtask

  task automatic expectReg(int lane, int r, logic [15:0] exp, string tag);
    rdLane = 3'(lane); rdReg = 3'(r);
    #1;
    check(rdData === exp, tag, rdData, exp);
  endtask

  task automatic putConst(int a, logic [15:0] v);
    cstWe = 1; cstAddr = 4'(a); cstData = v;
    idle(1);
  endtask

  task automatic putReg(int lane, int r, logic [15:0] v);
    ldEn = 1; ldLane = 3'(lane); ldReg = 3'(r); ldData = v;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] seedVals [8];
    for (int l = 0; l < 8; l++) begin
      for (int r = 0; r < 8; r++) mReg[l][r] = '0;
      mPres[l] = '0;
    end
    for (int k = 0; k < 16; k++) mCst[k] = '0;
    mMask = 8'hFF; mPv = 0; mPdst = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    #1;
    check(iReady === 1'b1, "R1 ready after reset", 16'(iReady), 16'd1);
    check(actMask === 8'hFF, "R1 mask after reset", 16'(actMask), 16'h00FF);
    for (int l = 0; l < 8; l++)
      for (int r = 0; r < 8; r++) expectReg(l, r, 16'h0000, "R1 reg cleared");
    issue(mk(4, 6, ks(9), LIT0, LIT0, 16'h0, 16'h0));
    idle(1);
    expectReg(3, 6, 16'h0000, "R1 constant cleared");

    seedVals = '{16'h0180, 16'hFE80, 16'h0040, 16'h7F00, 16'h8000, 16'h0000, 16'h0100, 16'hFFFF};
    for (int l = 0; l < 8; l++) putReg(l, 0, seedVals[l]);
    putConst(0, 16'h0080);
    putConst(1, 16'h0200);
    putConst(2, 16'h0100);

    // R3 mul with rounding and saturation
    issue(mk(1, 1, rs(0), ks(0), LIT0, 16'h0, 16'h0));
    issue(mk(1, 2, rs(0), ks(1), LIT0, 16'h0, 16'h0));
    // R4 madd
    issue(mk(2, 3, rs(0), ks(2), LIT0, 16'h0100, 16'h0));
    // R5 clamp to [0,1]
    issue(mk(3, 5, rs(0), LIT0, LIT1, 16'h0000, 16'h0100));
    idle(1);
    expectReg(0, 1, 16'h00C0, "R3 mul positive");
    expectReg(1, 1, 16'hFF40, "R3 mul negative");
    expectReg(7, 1, 16'h0000, "R3 round toward zero");
    expectReg(4, 1, 16'hC000, "R3 mul large negative");
    expectReg(3, 2, 16'h7FFF, "R3 saturate high");
    expectReg(4, 2, 16'h8000, "R3 saturate low");
    expectReg(0, 3, 16'h0280, "R4 madd");
    expectReg(3, 3, 16'h7FFF, "R4 madd saturate");
    expectReg(4, 3, 16'h8100, "R4 madd negative");
    expectReg(7, 3, 16'h00FF, "R4 madd truncated product");
    expectReg(0, 5, 16'h0100, "R5 clamp high");
    expectReg(1, 5, 16'h0000, "R5 clamp low");
    expectReg(2, 5, 16'h0040, "R5 clamp pass");
    issue(mk(3, 5, LIT0, LIT0, LIT1, 16'h0200, 16'h0100));
    idle(1);
    expectReg(6, 5, 16'h0100, "R5 inverted bounds give upper");

    // R9 hazard: read of in-flight destination stalls one cycle
    issue(mk(4, 4, LIT0, LIT0, LIT0, 16'h0300, 16'h0));
    iWord = mk(4, 6, rs(4), LIT0, LIT0, 16'h0, 16'h0);
    #1;
    check(iReady === 1'b0, "R9 stall on dependent read", 16'(iReady), 16'd0);
    issue(mk(4, 6, rs(4), LIT0, LIT0, 16'h0, 16'h0));
    idle(1);
    expectReg(2, 6, 16'h0300, "R9 dependent read sees new value");

    // R7 R8 divergence
    issue(mk(5, 0, rs(0), LIT0, LIT0, 16'h0, 16'h0));
    #1;
    check(actMask === 8'h4D, "R7 compare mask", 16'(actMask), 16'h004D);
    issue(mk(4, 7, LIT0, LIT0, LIT0, 16'h1111, 16'h0));
    issue(mk(6, 0, LIT0, LIT0, LIT0, 16'h0, 16'h0));
    #1;
    check(actMask === 8'hB2, "R7 invert mask", 16'(actMask), 16'h00B2);
    issue(mk(4, 7, LIT1, LIT0, LIT0, 16'h0, 16'h2222));
    issue(mk(7, 0, LIT0, LIT0, LIT0, 16'h0, 16'h0));
    idle(1);
    check(actMask === 8'hFF, "R7 restore mask", 16'(actMask), 16'h00FF);
    expectReg(0, 7, 16'h1111, "R8 if-path lane kept");
    expectReg(1, 7, 16'h2222, "R8 else-path lane");
    expectReg(6, 7, 16'h1111, "R8 masked lane untouched");
    issue(mk(0, 0, LIT0, LIT0, LIT0, 16'h5555, 16'h5555));
    idle(1);
    expectReg(0, 0, 16'h0180, "R8 nop writes nothing");

    // R6 writeback timing
    issue(mk(4, 1, LIT0, LIT0, LIT0, 16'h0ABC, 16'h0));
    expectReg(0, 1, 16'h00C0, "R6 old value before writeback");
    idle(1);
    expectReg(0, 1, 16'h0ABC, "R6 new value after writeback");

    // R10 constant write on same edge as accept
    cstWe = 1; cstAddr = 4'd5; cstData = 16'h0500;
    issue(mk(4, 2, ks(5), LIT0, LIT0, 16'h0, 16'h0));
    issue(mk(4, 3, ks(5), LIT0, LIT0, 16'h0, 16'h0));
    idle(1);
    expectReg(0, 2, 16'h0000, "R10 same-edge sees old constant");
    expectReg(0, 3, 16'h0500, "R10 later sees new constant");

    // R11 load vs writeback collision
    issue(mk(4, 4, LIT0, LIT0, LIT0, 16'h0777, 16'h0));
    ldEn = 1; ldLane = 3'd0; ldReg = 3'd4; ldData = 16'h0999;
    idle(1);
    expectReg(0, 4, 16'h0777, "R11 writeback wins");
    putReg(0, 4, 16'h0999);
    expectReg(0, 4, 16'h0999, "R11 load alone");

    // R2 mixed random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] sa, sb, sc;
      sa = 6'($urandom); sb = 6'($urandom); sc = 6'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        ldEn = 1; ldLane = 3'($urandom); ldReg = 3'($urandom); ldData = 16'($urandom);
      end
      if ($urandom_range(0, 3) == 0) begin
        cstWe = 1; cstAddr = 4'($urandom); cstData = 16'($urandom);
      end
      rdLane = 3'($urandom); rdReg = 3'($urandom);
      issue(mk($urandom_range(0, 8), $urandom_range(0, 7), sa, sb, sc,
               16'($urandom), 16'($urandom)));
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(2);
    check(nStalls > 0, "R9 stalls exercised", 16'(nStalls), 16'd1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule